// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit decides whether a branch is taken and where it goes. A request carries a four-bit branch kind, the four condition flags (negative, zero, overflow, carry), the program counter of the branch, an eight-bit offset and a loop counter value. The unit reports three results. The first is taken or not taken. The second is the target address. The third is the counter value the loop form writes back. Fetching the instruction and writing the program counter are left to the surrounding pipeline.

Each request runs through a three-state controller. `ST_IDLE` waits for a request. The transition *accept* (IDLE to EVAL) fires when `req_valid` is high and `in_ready` is high, and it captures the operands. `ST_EVAL` computes the decision. The transition *compute* (EVAL to DONE) registers the results. `ST_DONE` raises `res_valid` for one cycle. The transition *retire* (DONE to IDLE) returns the controller to waiting. The result registers keep their values until the next result.

Ordinary branches take a signed offset counted in words. The offset is doubled and added to the program counter. The loop kind first decrements the counter. It then branches backward by an unsigned six-bit word count, and only when the new counter value is nonzero.

Top module: `branch_decide_unit`

## Requirements
- R1: During reset and after it is released, `in_ready` is 1, `res_valid` is 0, and `res_taken`, `res_target` and `res_count` are 0.
- R2: A request is accepted at a rising edge where `req_valid` and `in_ready` are both 1. After that edge `in_ready` is 0 for two cycles. `res_valid` is 1 for exactly the one cycle that follows the next edge, and `in_ready` returns to 1 after the edge that follows it.
- R3: A request presented while `in_ready` is 0 is ignored. It produces no result and does not change the result of the request in flight.
- R4: Kind 1 (equal) is taken when Z=1. Kind 2 (not equal) is taken when Z=0.
- R5: Kind 3 (signed greater or equal) is taken when N equals V. Kind 4 (signed less or equal) is taken when Z=1 or N differs from V.
- R6: Kind 5 (unsigned higher) is taken when C=0 and Z=0. Kind 6 (higher or same) is taken when C=0. Kind 7 (lower) is taken when C=1.
- R7: Kind 0 is always taken. For kinds 0 to 7 and 9 to 15, `res_target` = pc + 2 × signed offset, modulo 2^16. This covers -128 to +127 words, and the target is reported whether or not the branch is taken.
- R8: Kind 8 (loop) gives `res_count` = count − 1, modulo 2^16. It is taken exactly when that value is nonzero. `res_target` = pc − 2 × offset[5:0], and offset bits 7:6 have no effect.
- R9: For every kind other than 8, `res_count` equals the request's count unchanged.
- R10: Kinds 9 to 15 are never taken.
- R11: `res_taken`, `res_target` and `res_count` hold their values from one result until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 4 | Branch kind code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| req_pc | input | 16 | Program counter of the branch |
| req_offset | input | 8 | Word offset (signed; low six bits unsigned for the loop kind) |
| req_count | input | 16 | Loop counter value |
| in_ready | output | 1 | Controller idle, request can be accepted |
| res_valid | output | 1 | Result strobe, one cycle |
| res_taken | output | 1 | Branch taken |
| res_target | output | 16 | Branch target address |
| res_count | output | 16 | Counter value to write back |

## Verification
Each result is due at a fixed distance from its accept edge. `res_valid` and the three result fields appear after the first edge that follows acceptance. `in_ready` stays low through that edge and the next one. The bench notes the cycle number of each accept edge and stores the expected results in a queue keyed to that cycle plus one. It then compares the strobe, the ready flag and the held outputs at every falling edge. Any result that comes early or late, or a request taken while the unit is busy, shows up as a mismatch in the exact cycle where it happens.

// File: rtl/bdu_pkg.sv
package bdu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } bdu_state_e;

    typedef enum logic [3:0] {
        BK_ALWAYS = 4'd0,
        BK_EQ     = 4'd1,
        BK_NE     = 4'd2,
        BK_SGE    = 4'd3,
        BK_SLE    = 4'd4,
        BK_UHI    = 4'd5,
        BK_UHS    = 4'd6,
        BK_ULO    = 4'd7,
        BK_LOOP   = 4'd8
    } br_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

endpackage

// File: rtl/bdu_cond.sv
module bdu_cond
    import bdu_pkg::*;
(
    input  cc_flags_t  flags,
    input  logic [3:0] kind,
    input  logic       cnt_nonzero,
    output logic       take
);
    logic signed_ge;

    always_comb begin
        signed_ge = (flags.n == flags.v);
        case (kind)
            BK_ALWAYS: take = 1'b1;
            BK_EQ:     take = flags.z;
            BK_NE:     take = ~flags.z;
            BK_SGE:    take = signed_ge;
            BK_SLE:    take = flags.z | ~signed_ge;
            BK_UHI:    take = ~flags.c & ~flags.z;
            BK_UHS:    take = ~flags.c;
            BK_ULO:    take = flags.c;
            BK_LOOP:   take = cnt_nonzero;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bdu_addr.sv
module bdu_addr #(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 8,
    parameter int LOOP_OFF_W = 6,
    parameter int CNT_W      = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_loop,
    input  logic [CNT_W-1:0]  count_in,
    output logic [ADDR_W-1:0] target,
    output logic [CNT_W-1:0]  count_out,
    output logic              count_nonzero
);
    localparam int SEXT_W = ADDR_W - OFF_W;
    localparam int ZEXT_W = ADDR_W - LOOP_OFF_W;

    logic [ADDR_W-1:0] fwd_words;
    logic [ADDR_W-1:0] back_words;
    logic [ADDR_W-1:0] fwd_target;
    logic [ADDR_W-1:0] back_target;
    logic [CNT_W-1:0]  decremented;

    generate
        if (SEXT_W > 0) begin : g_sext
            assign fwd_words = {{SEXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign fwd_words = offset[ADDR_W-1:0];
        end
    endgenerate

    assign back_words  = {{ZEXT_W{1'b0}}, offset[LOOP_OFF_W-1:0]};
    assign fwd_target  = pc + (fwd_words << 1);
    assign back_target = pc - (back_words << 1);
    assign decremented = count_in - {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (is_loop) begin
            target    = back_target;
            count_out = decremented;
        end else begin
            target    = fwd_target;
            count_out = count_in;
        end
        count_nonzero = |decremented;
    end
endmodule

// File: rtl/branch_decide_unit.sv
module branch_decide_unit
    import bdu_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 8,
    parameter int LOOP_OFF_W = 6,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [CNT_W-1:0]  req_count,
    output logic              in_ready,
    output logic              res_valid,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_target,
    output logic [CNT_W-1:0]  res_count
);
    bdu_state_e        state_q, state_d;
    cc_flags_t         flags_q;
    logic [3:0]        kind_q;
    logic [ADDR_W-1:0] pc_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              accept;
    logic              comp_take;
    logic [ADDR_W-1:0] comp_target;
    logic [CNT_W-1:0]  comp_count;
    logic              comp_nonzero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: accept, compute, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode from state
    always_comb begin
        in_ready  = 1'b0;
        res_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_EVAL: ;
            ST_DONE: res_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = in_ready & req_valid;

    // operand capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            kind_q  <= '0;
            pc_q    <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            flags_q <= '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};
            kind_q  <= req_kind;
            pc_q    <= req_pc;
            off_q   <= req_offset;
            cnt_q   <= req_count;
        end
    end

    bdu_addr #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .LOOP_OFF_W(LOOP_OFF_W),
        .CNT_W     (CNT_W)
    ) u_addr (
        .pc           (pc_q),
        .offset       (off_q),
        .is_loop      (kind_q == BK_LOOP),
        .count_in     (cnt_q),
        .target       (comp_target),
        .count_out    (comp_count),
        .count_nonzero(comp_nonzero)
    );

    bdu_cond u_cond (
        .flags      (flags_q),
        .kind       (kind_q),
        .cnt_nonzero(comp_nonzero),
        .take       (comp_take)
    );

    // result registers, loaded on the compute transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_taken  <= 1'b0;
            res_target <= '0;
            res_count  <= '0;
        end else if (state_q == ST_EVAL) begin
            res_taken  <= comp_take;
            res_target <= comp_target;
            res_count  <= comp_count;
        end
    end
endmodule

// File: rtl/bdu_checker.sv
module bdu_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              in_ready,
    input logic              res_valid,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic [CNT_W-1:0]  res_count,
    input logic [3:0]        kind_q
);
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && req_valid) |=> (!in_ready && !res_valid));

    p_result_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && req_valid) |=> ##1 res_valid);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && in_ready));

    p_busy_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && req_valid) |=> $stable(kind_q));

    p_loop_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && kind_q == 4'd8) |-> (res_taken == (res_count != '0)));

    p_reserved_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && kind_q > 4'd8) |-> !res_taken);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ($stable(res_taken) && $stable(res_target) && $stable(res_count)));
endmodule

bind branch_decide_unit bdu_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_bdu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .res_taken (res_taken),
    .res_target(res_target),
    .res_count (res_count),
    .kind_q    (kind_q)
);

// File: tb/tb_branch_decide_unit.sv
`timescale 1ns/1ps
module tb_branch_decide_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic [15:0] req_pc = '0;
    logic [7:0]  req_offset = '0;
    logic [15:0] req_count = '0;
    logic        in_ready, res_valid, res_taken;
    logic [15:0] res_target, res_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int busy_until = -1;
    bit have_last = 0;
    bit l_taken;
    logic [15:0] l_target, l_count;
    bit done = 0;

    int          q_due[$];
    bit          q_taken[$];
    logic [15:0] q_target[$];
    logic [15:0] q_count[$];
    int          q_kind[$];

    always #2.5 clk = ~clk;

    branch_decide_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .req_pc(req_pc), .req_offset(req_offset), .req_count(req_count),
        .in_ready(in_ready), .res_valid(res_valid), .res_taken(res_taken),
        .res_target(res_target), .res_count(res_count)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic string tag_of(input int k);
        if (k == 1 || k == 2) return "R4";
        if (k == 3 || k == 4) return "R5";
        if (k >= 5 && k <= 7) return "R6";
        if (k == 0) return "R7";
        if (k == 8) return "R8";
        return "R10";
    endfunction

    // behavioural reference
    task automatic predict(input int k, input bit n, input bit z, input bit v, input bit c,
                           input int pc, input int off, input int cnt,
                           output bit tk, output logic [15:0] tg, output logic [15:0] ct);
        int soff, nc;
        soff = (off >= 128) ? off - 256 : off;
        nc   = (cnt - 1) & 16'hFFFF;
        ct   = (k == 8) ? nc[15:0] : cnt[15:0];
        if (k == 8) tg = 16'((pc - 2 * (off % 64)) & 16'hFFFF);
        else        tg = 16'((pc + 2 * soff) & 16'hFFFF);
        case (k)
            0: tk = 1;
            1: tk = z;
            2: tk = !z;
            3: tk = (n == v);
            4: tk = z || (n != v);
            5: tk = !c && !z;
            6: tk = !c;
            7: tk = c;
            8: tk = (nc != 0);
            default: tk = 0;
        endcase
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(in_ready == (cyc > busy_until), "R2", "in_ready", in_ready, cyc > busy_until);
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                check(res_valid == 1'b1, "R2", "res_valid due", res_valid, 1);
                check(res_taken == q_taken[0], tag_of(q_kind[0]), "res_taken", res_taken, q_taken[0]);
                check(res_target == q_target[0], (q_kind[0] == 8) ? "R8" : "R7", "res_target",
                      res_target, q_target[0]);
                check(res_count == q_count[0], (q_kind[0] == 8) ? "R8" : "R9", "res_count",
                      res_count, q_count[0]);
                have_last = 1;
                l_taken = q_taken[0]; l_target = q_target[0]; l_count = q_count[0];
                void'(q_due.pop_front()); void'(q_taken.pop_front());
                void'(q_target.pop_front()); void'(q_count.pop_front());
                void'(q_kind.pop_front());
            end else begin
                check(res_valid == 1'b0, "R2 R3", "res_valid idle", res_valid, 0);
                if (have_last)
                    check(res_taken == l_taken && res_target == l_target && res_count == l_count,
                          "R11", "held outputs", {res_taken, res_target, res_count},
                          {l_taken, l_target, l_count});
            end
        end
    end

    task automatic issue(input int k, input bit n, input bit z, input bit v, input bit c,
                         input int pc, input int off, input int cnt, input bit junk);
        bit tk; logic [15:0] tg, ct;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        predict(k, n, z, v, c, pc, off, cnt, tk, tg, ct);
        req_kind = 4'(k); flag_n = n; flag_z = z; flag_v = v; flag_c = c;
        req_pc = 16'(pc); req_offset = 8'(off); req_count = 16'(cnt);
        req_valid = 1'b1;
        @(posedge clk); #1;
        q_due.push_back(cyc + 1); q_taken.push_back(tk); q_target.push_back(tg);
        q_count.push_back(ct); q_kind.push_back(k);
        busy_until = cyc + 1;
        if (junk) begin
            // R3: requests during EVAL and DONE must be ignored
            req_kind = 4'(15 - k); flag_z = !z; flag_c = !c;
            req_pc = 16'(pc ^ 16'h5A5A); req_offset = 8'(off ^ 8'hFF); req_count = 16'(cnt + 7);
            @(posedge clk); @(posedge clk); #1;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values, during reset
        check(in_ready == 1 && res_valid == 0, "R1", "ready/valid in reset", {in_ready, res_valid}, 2'b10);
        check(res_taken == 0 && res_target == 0 && res_count == 0, "R1", "results in reset",
              {res_taken, res_target, res_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1 && res_valid == 0 && res_target == 0, "R1", "after release",
              {in_ready, res_valid, res_target}, {2'b10, 16'h0});
        // all kinds against all flag combinations
        for (int k = 0; k < 16; k++)
            for (int f = 0; f < 16; f++)
                issue(k, f[3], f[2], f[1], f[0], 16'h1000 + 2 * f + 64 * k, (k * 37 + f * 11) % 256,
                      (f == 3) ? 1 : 300 + f, 0);
        // R7 boundaries: extreme offsets and wrap
        issue(0, 0, 0, 0, 0, 16'h2000, 8'h80, 5, 0);
        issue(0, 0, 0, 0, 0, 16'h2000, 8'h7F, 5, 0);
        issue(0, 0, 0, 0, 0, 16'hFFFE, 8'h01, 5, 0);
        issue(0, 0, 0, 0, 0, 16'h0000, 8'hFF, 5, 0);
        // R8 boundaries: count 1 falls to zero, count 0 wraps, upper offset bits ignored
        issue(8, 0, 0, 0, 0, 16'h3000, 8'h3F, 1, 0);
        issue(8, 1, 1, 1, 1, 16'h3000, 8'hFF, 0, 0);
        issue(8, 0, 0, 0, 0, 16'h3000, 8'hC5, 2, 0);
        issue(8, 0, 0, 0, 0, 16'h0004, 8'h3F, 9, 0);
        // R3: busy-time requests
        issue(1, 0, 1, 0, 0, 16'h4000, 8'h10, 44, 1);
        issue(8, 0, 0, 0, 0, 16'h4100, 8'h02, 3, 1);
        issue(7, 0, 0, 0, 1, 16'h4200, 8'hF0, 77, 1);
        repeat (6) @(negedge clk);
        check(q_due.size() == 0, "R2", "pending results drained", q_due.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule